// File: doc/BRIEF.md
# T1-to-Local Frame Phase Monitor

This block measures where a received 1.544 Mb/s T1 frame sits relative to a local 32-channel, 2.048 Mb/s TDM frame. It has two parts. The receive side counts the 193 bit positions of the T1 frame and raises a marker at a fixed point in that frame. The local side runs a free 8-bit position counter, one count per local bit, that restarts on the local frame pulse. It brings the marker across clock domains and, on each marker rising edge, captures the current local position as a phase word.

The upper five bits of the phase word are the local channel and the lower three bits are the bit within that channel. A ninth frame-count bit extends the reading: it toggles whenever successive readings cross the local frame boundary in either direction. The phase word also goes out serially in status timeslot 3 of the local frame. A slow external loop can read how the reading trends over time to steer the local clock.

Top module: `frame_phase_monitor`

## Requirements
- R1: The receive position is 0 on the framing bit, and the 24 channels, numbered from 0, follow at 8 bits each. The position restarts at 0 on the rx clock edge that samples `rxFrameStart` high, and otherwise wraps from 192 to 0. `rxMarker` rises on the rx edge where the position becomes 139, which is bit 2 of channel 17, and it stays high until the position wraps.
- R2: The local position counter is 8 bits wide. It is 0 in the cycle after a clock edge that samples `locFramePulse` high, then increments once per clock and wraps from 255 to 0.
- R3: After each `rxMarker` rising edge, `phaseWord` loads on the third local rising edge that follows the marker edge. It takes the value the local position counter held just before that edge. Bits 7:3 are the channel and bits 2:0 are the bit.
- R4: Each marker rising edge causes exactly one capture. Between captures, `phaseWord` holds its value.
- R5: The first capture after reset never toggles `frameCount`.
- R6: `frameCount` toggles when a capture lies more than 128 positions below the previous one (a forward wrap).
- R7: `frameCount` toggles when a capture lies more than 128 positions above the previous one (a backward wrap).
- R8: A change of 128 positions or less, in either direction, leaves `frameCount` unchanged.
- R9: When T1 frames arrive faster than local frames, successive readings decrease. When they arrive slower, successive readings increase.
- R10: While the local position is 24 to 31 (status timeslot 3), `statusOut` carries the phase word MSB first. The word is latched on the edge where the position goes from 23 to 24. At every other position `statusOut` is 0.
- R11: During reset and after it, `phaseWord` is 0, `frameCount` is 0 and `statusOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bit clock, one position per cycle |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| locFramePulse | input | 1 | Local frame start, one cycle wide |
| rxClk | input | 1 | Recovered T1 bit clock |
| rxFrameStart | input | 1 | Marks the T1 framing bit, one rx cycle wide |
| phaseWord | output | 8 | Captured local position: channel in bits 7:3, bit in bits 2:0 |
| frameCount | output | 1 | Ninth bit of the phase reading; toggles on a boundary wrap |
| statusOut | output | 1 | Serial status stream; phase word in timeslot 3 |
| rxMarker | output | 1 | Receive-side marker, rx clock domain |

## Verification
The bench steps the T1 frame start against the local frame by periods shorter than, equal to and longer than a local frame, so readings hold, fall and rise. A swapped comparison in the wrap detector would show up as wrong readings here. The bench drives readings across the 255/0 boundary both ways and checks that the frame-count bit toggles. A design that compares without wraparound, or mixes up the two directions, would miss a toggle or add a spurious one. It checks the very first capture after reset, which a design lacking a valid-reference flag would treat as a wrap. It also checks a jump of exactly 128, which an off-by-one threshold would count as a wrap. The serial timeslot is checked bit by bit against the expected word, which exposes bit reversal or a slot shifted by one position.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic sampleStb; // capture local position now
    logic slotLoad;  // latch phase word for serial slot
    logic inSlot;    // local position inside status slot
  } fpmStrobes_t;
endpackage

// File: rtl/fpm_rx_marker.sv
module fpm_rx_marker #(
  parameter int RX_FRAME_BITS = 193,
  parameter int MARK_CHAN     = 17,
  parameter int MARK_BIT      = 2,
  parameter int BIT_W         = 3
) (
  input  logic rxClk,
  input  logic rstN,
  input  logic rxFrameStart,
  output logic rxMarker
);
  localparam int RX_W     = $clog2(RX_FRAME_BITS);
  localparam int MARK_POS = 1 + MARK_CHAN * (1 << BIT_W) + MARK_BIT;
  localparam logic [RX_W-1:0] LAST_POS = RX_W'(RX_FRAME_BITS - 1);
  localparam logic [RX_W-1:0] MARK_V   = RX_W'(MARK_POS);

  logic [RX_W-1:0] rxPos;
  logic [RX_W-1:0] rxPosNext;

  always_comb begin
    if (rxFrameStart)           rxPosNext = '0;
    else if (rxPos == LAST_POS) rxPosNext = '0;
    else                        rxPosNext = rxPos + 1'b1;
  end

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN) begin
      rxPos    <= '0;
      rxMarker <= 1'b0;
    end else begin
      rxPos    <= rxPosNext;
      rxMarker <= (rxPosNext >= MARK_V);
    end
  end

  AST_RX_RESTART: assert property (@(posedge rxClk) disable iff (!rstN)
    rxFrameStart |=> rxPos == '0); // R1
  AST_MARK_RISE: assert property (@(posedge rxClk) disable iff (!rstN)
    $rose(rxMarker) |-> rxPos == MARK_V); // R1
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int CHAN_W      = 5,
  parameter int BIT_W       = 3,
  parameter int SLOT        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      locFramePulse,
  input  logic                      rxMarker,
  output logic [CHAN_W+BIT_W-1:0]   locPos,
  output fpmStrobes_t               strb
);
  localparam int POS_W = CHAN_W + BIT_W;
  localparam logic [POS_W-1:0]  LOAD_POS = POS_W'(SLOT * (1 << BIT_W) - 1);
  localparam logic [CHAN_W-1:0] SLOT_V   = CHAN_W'(SLOT);

  // synchronizer chain plus one stage for edge detection
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locPos <= '0;
      syncQ  <= '0;
    end else begin
      locPos <= locFramePulse ? '0 : locPos + 1'b1;
      syncQ  <= {syncQ[SYNC_STAGES-1:0], rxMarker};
    end
  end

  always_comb begin
    strb.sampleStb = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
    strb.slotLoad  = (locPos == LOAD_POS);
    strb.inSlot    = (locPos[POS_W-1:BIT_W] == SLOT_V);
  end

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    locFramePulse |=> locPos == '0); // R2
  AST_SINGLE_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleStb |=> !strb.sampleStb); // R4
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] locPos,
  input  fpmStrobes_t      strb,
  output logic [POS_W-1:0] phaseWord,
  output logic             frameCount,
  output logic             statusOut
);
  localparam logic [POS_W-1:0] HALF = POS_W'(1 << (POS_W - 1));

  logic             haveRef;
  logic [POS_W-1:0] downDist;
  logic [POS_W-1:0] upDist;
  logic             fwdWrap;
  logic             bwdWrap;
  logic [POS_W-1:0] slotShift;

  always_comb begin
    downDist = phaseWord - locPos;
    upDist   = locPos - phaseWord;
    fwdWrap  = haveRef && (locPos < phaseWord) && (downDist > HALF);
    bwdWrap  = haveRef && (locPos > phaseWord) && (upDist > HALF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseWord  <= '0;
      frameCount <= 1'b0;
      haveRef    <= 1'b0;
    end else if (strb.sampleStb) begin
      phaseWord <= locPos;
      haveRef   <= 1'b1;
      if (fwdWrap || bwdWrap) frameCount <= ~frameCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              slotShift <= '0;
    else if (strb.slotLoad) slotShift <= phaseWord;
    else if (strb.inSlot)   slotShift <= slotShift << 1;
  end

  assign statusOut = strb.inSlot & slotShift[POS_W-1];

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleStb |=> phaseWord == $past(locPos)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleStb |=> $stable(phaseWord)); // R4
  AST_FC_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sampleStb |=> $stable(frameCount)); // R6
  AST_SLOT_FIRST_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotLoad |=> statusOut == $past(phaseWord[POS_W-1])); // R10
endmodule

// File: rtl/frame_phase_monitor.sv
module frame_phase_monitor
  import fpm_pkg::*;
#(
  parameter int CHAN_W        = 5,
  parameter int BIT_W         = 3,
  parameter int RX_FRAME_BITS = 193,
  parameter int MARK_CHAN     = 17,
  parameter int MARK_BIT      = 2,
  parameter int STATUS_SLOT   = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    locFramePulse,
  input  logic                    rxClk,
  input  logic                    rxFrameStart,
  output logic [CHAN_W+BIT_W-1:0] phaseWord,
  output logic                    frameCount,
  output logic                    statusOut,
  output logic                    rxMarker
);
  localparam int POS_W = CHAN_W + BIT_W;

  logic [POS_W-1:0] locPos;
  fpmStrobes_t      strb;

  fpm_rx_marker #(
    .RX_FRAME_BITS(RX_FRAME_BITS), .MARK_CHAN(MARK_CHAN),
    .MARK_BIT(MARK_BIT), .BIT_W(BIT_W)
  ) uRx (
    .rxClk(rxClk), .rstN(rstN), .rxFrameStart(rxFrameStart), .rxMarker(rxMarker)
  );

  fpm_ctrl #(
    .CHAN_W(CHAN_W), .BIT_W(BIT_W), .SLOT(STATUS_SLOT), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .locFramePulse(locFramePulse),
    .rxMarker(rxMarker), .locPos(locPos), .strb(strb)
  );

  fpm_datapath #(.POS_W(POS_W)) uDp (
    .clk(clk), .rstN(rstN), .locPos(locPos), .strb(strb),
    .phaseWord(phaseWord), .frameCount(frameCount), .statusOut(statusOut)
  );
endmodule

// File: tb/tb_frame_phase_monitor.sv
module tb_frame_phase_monitor;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       locF = 1'b0;
  logic       rxS = 1'b0;
  logic       rxClk;
  logic [7:0] phaseWord;
  logic       frameCount;
  logic       statusOut;
  logic       rxMarker;

  int checks = 0;
  int errors = 0;
  int since;
  logic [7:0] locModel;
  logic [7:0] serByte;

  always #4 clk = ~clk;
  assign rxClk = ~clk;

  frame_phase_monitor dut (
    .clk(clk), .rstN(rstN), .locFramePulse(locF), .rxClk(rxClk),
    .rxFrameStart(rxS), .phaseWord(phaseWord), .frameCount(frameCount),
    .statusOut(statusOut), .rxMarker(rxMarker)
  );

  // model of the local position (R2)
  always @(posedge clk or negedge rstN) begin
    if (!rstN)     locModel <= 8'd0;
    else if (locF) locModel <= 8'd0;
    else           locModel <= locModel + 8'd1;
  end

  // collect the status slot bits (R10)
  always @(negedge clk) begin
    if (locModel >= 8'd24 && locModel <= 8'd31) serByte <= {serByte[6:0], statusOut};
  end

  // vector: gap(9) expected phase(8) expected frameCount(1)
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {9'd1,   8'd141, 1'b0},  // first capture, no toggle R5
    {9'd256, 8'd141, 1'b0},  // equal rates
    {9'd255, 8'd140, 1'b0},  // rx faster, decreases R9
    {9'd257, 8'd141, 1'b0},  // rx slower, increases R9
    {9'd300, 8'd185, 1'b0},
    {9'd321, 8'd250, 1'b0},
    {9'd266, 8'd4,   1'b1},  // forward wrap R6
    {9'd246, 8'd250, 1'b0},  // backward wrap R7
    {9'd266, 8'd4,   1'b1},  // forward wrap R6
    {9'd316, 8'd64,  1'b1},  // small rise R8
    {9'd160, 8'd224, 1'b0}   // rise of 160 counts as backward wrap R7
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stepTo(input int n);
    if (n > 0) begin
      repeat (n) @(posedge clk);
      #2;
    end
  endtask

  task automatic checkSerial(input logic [7:0] exp);
    @(negedge clk);
    while (locModel != 8'd32) @(negedge clk);
    check("R10 status slot word", serByte, exp);
    check("R10 status idle outside slot", statusOut, 0);
    check("R4 phase word held", phaseWord, exp);
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    stepTo(3);
    check("R11 reset phaseWord", phaseWord, 0);
    check("R11 reset frameCount", frameCount, 0);
    check("R11 reset statusOut", statusOut, 0);
    rstN = 1'b1;
    stepTo(2);
    check("R11 phaseWord after reset", phaseWord, 0);

    locF = 1'b1;
    stepTo(1);
    locF = 1'b0;
    since = 1;
    for (int i = 0; i < NV; i++) begin
      stepTo(int'(VEC[i][17:9]) - since);
      rxS = 1'b1;
      stepTo(1);
      rxS = 1'b0;
      stepTo(145);
      since = 146;
      check("R1 R3 R9 phase word", phaseWord, int'(VEC[i][8:1]));
      check("R5 R6 R7 R8 frame count", frameCount, int'(VEC[i][0]));
    end

    checkSerial(8'd224);

    // realign both frames: drop of exactly 128 must not toggle (R8)
    stepTo(1);
    rxS = 1'b1;
    stepTo(1);
    rxS = 1'b0;
    stepTo(43);
    locF = 1'b1;
    stepTo(1);
    locF = 1'b0;
    stepTo(101);
    check("R2 R3 phase after local realign", phaseWord, 96);
    check("R8 drop of 128 keeps frame count", frameCount, 0);
    checkSerial(8'd96);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule